// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM (13 row bits, 4 internal banks, 16-bit data) from reset to a usable state. After reset it raises clock enable, waits a stabilization period, then issues one precharge of all banks, a burst of auto-refresh commands and one mode-register load. It keeps a minimum cycle spacing after each command.

Every step waits first for a controller-ready input. If ready does not arrive within a bounded number of cycles, the sequence stops and a fault flag is raised. Once the mode-register gap has elapsed, `init_done` rises and a periodic refresh timer takes over. The timer raises a refresh request once per interval and holds it until the request is acknowledged. The refresh interval is derived from the retention time, the row count and the SDRAM clock frequency, less a fixed safety margin.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is applied, `cke` is low, the command pins carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), and `init_done`, `init_error` and `refresh_req` are low.
- R2: The commands appear in this order: `cke` rise, one precharge (0010), `INIT_REFRESHES` (8) auto-refreshes (0001), one load-mode (0000). No other command appears, and none appears while `cke` is low.
- R3: The precharge is no earlier than `PWRUP_CYCLES` cycles after `cke` rises. When ready is already high, it comes exactly `PWRUP_CYCLES`+1 cycles after the rise.
- R4: The auto-refresh burst is issued back to back, exactly `T_RFC` (7) cycles apart. The first refresh is at least `T_PRE` (3) cycles after the precharge, and the load-mode is at least `T_RFC` cycles after the last refresh.
- R5: Only the four codes NOP 0111, precharge 0010, auto-refresh 0001 and load-mode 0000 appear. During a precharge, address bit 10 is high, which selects all banks.
- R6: During load-mode, the address carries the mode word and `ba` is 0. The mode word has burst length code in [2:0] (0 means 1 beat), interleave in bit 3, CAS latency in [6:4], operating mode in [8:7] (0) and single-location writes in bit 9. The default word is 0x230.
- R7: `init_done` rises `T_MRD` (2) cycles after the load-mode cycle and stays high. No command is driven after it rises.
- R8: Each step (CKE, precharge, refresh burst, load-mode) waits for `ctrl_ready`. The step's action appears in the cycle after the first clock edge that samples `ctrl_ready` high.
- R9: If `ctrl_ready` stays low for `WAIT_LIMIT` consecutive sampled edges of a step wait, `init_error` rises on that edge and stays high. No further command follows, and `init_done` never rises.
- R10: After `init_done`, `refresh_req` rises every `REFI` cycles, with the first rise `REFI` cycles after `init_done`. It stays high until the edge that samples `refresh_ack` high, and falls after that edge.
- R11: `REFI` = `RETENTION_US`*`SDCLK_MHZ`/`ROW_COUNT` - `REFRESH_MARGIN`. The defaults give 761.
- R12: Once `cke` has risen, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM command clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_ready | input | 1 | Controller not busy; gates each initialization step |
| refresh_ack | input | 1 | Acknowledges a pending refresh request |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address bus (A10 = all banks, mode word during load-mode) |
| init_done | output | 1 | Initialization complete |
| init_error | output | 1 | Ready wait timed out; sequence aborted |
| refresh_req | output | 1 | Periodic refresh request, held until acknowledged |

## Verification
The properties take `ctrl_ready` to be arbitrary. They also assume `refresh_ack` is a pulse given only while a request is pending and before the next interval ends, so a held request is never re-armed and overtaken. The stimulus holds `ctrl_ready` low only in windows anchored to observed events (reset release, the CKE rise, the first refresh, the precharge). It sweeps the window length across the whole range from no effect, through a delayed precharge, to a timeout. Acknowledges are single-cycle pulses issued a fixed number of cycles after each observed request rise, well inside the interval.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    SEQ_HANDSHAKE,
    SEQ_SPACING,
    SEQ_RUNNING,
    SEQ_FAULT
  } seq_phase_e;

  // step order is behaviour: CKE, precharge, refresh burst, mode load
  typedef enum logic [1:0] {
    STEP_CKE,
    STEP_PRE,
    STEP_REF,
    STEP_LMR
  } seq_step_e;

  function automatic logic [15:0] mode_word(input int unsigned bl_code,
                                            input bit interleave,
                                            input int unsigned cas,
                                            input bit single_wr);
    logic [15:0] w;
    w       = '0;
    w[2:0]  = bl_code[2:0];
    w[3]    = interleave;
    w[6:4]  = cas[2:0];
    w[8:7]  = 2'b00;
    w[9]    = single_wr;
    return w;
  endfunction

endpackage

// File: rtl/sdram_boot_rstsync.sv
module sdram_boot_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdram_boot_downcnt.sv
module sdram_boot_downcnt #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (dec && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_boot_refresh_tmr.sv
module sdram_boot_refresh_tmr #(
  parameter int unsigned INTERVAL = 761
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic req
);
  localparam int unsigned W = $clog2(INTERVAL + 1);
  localparam logic [W-1:0] RELOAD = W'(INTERVAL - 1);

  logic run_q, run_d, req_q, req_d, tick, zero;

  assign tick = run_q & zero;

  sdram_boot_downcnt #(.W(W), .RST_VAL(RELOAD)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start | tick),
    .load_val (RELOAD),
    .dec      (run_q),
    .zero     (zero)
  );

  always_comb begin
    run_d = run_q | start;
    req_d = req_q;
    if (tick)     req_d = 1'b1;
    else if (ack) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      run_q <= run_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int unsigned ROW_W           = 13,
  parameter int unsigned BANK_COUNT      = 4,
  parameter int unsigned PWRUP_CYCLES    = 1000000,
  parameter int unsigned T_PRE           = 3,
  parameter int unsigned T_RFC           = 7,
  parameter int unsigned T_MRD           = 2,
  parameter int unsigned INIT_REFRESHES  = 8,
  parameter int unsigned WAIT_LIMIT      = 65535,
  parameter int unsigned RETENTION_US    = 64000,
  parameter int unsigned ROW_COUNT       = 8192,
  parameter int unsigned SDCLK_MHZ       = 100,
  parameter int unsigned REFRESH_MARGIN  = 20,
  parameter int unsigned MR_BURST_CODE   = 0,
  parameter bit          MR_INTERLEAVE   = 1'b0,
  parameter int unsigned MR_CAS          = 3,
  parameter bit          MR_WRITE_SINGLE = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctrl_ready,
  input  logic                          refresh_ack,
  output logic                          cke,
  output logic                          cs_n,
  output logic                          ras_n,
  output logic                          cas_n,
  output logic                          we_n,
  output logic [$clog2(BANK_COUNT)-1:0] ba,
  output logic [ROW_W-1:0]              addr,
  output logic                          init_done,
  output logic                          init_error,
  output logic                          refresh_req
);
  localparam int unsigned BANK_W = $clog2(BANK_COUNT);
  localparam int unsigned GAP_W  = $clog2(PWRUP_CYCLES + T_PRE + T_RFC + T_MRD + 1);
  localparam int unsigned WAIT_W = $clog2(WAIT_LIMIT + 1);
  localparam int unsigned REFS_W = $clog2(INIT_REFRESHES + 1);
  localparam int unsigned REFI_CYCLES =
    RETENTION_US * SDCLK_MHZ / ROW_COUNT - REFRESH_MARGIN;
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'(mode_word(MR_BURST_CODE, MR_INTERLEAVE, MR_CAS, MR_WRITE_SINGLE));
  localparam logic [WAIT_W-1:0] WAIT_RELOAD = WAIT_W'(WAIT_LIMIT - 1);

  logic              core_rst_n;
  seq_phase_e        phase_q, phase_d;
  seq_step_e         step_q, step_d;
  logic [REFS_W-1:0] refs_q, refs_d;
  sdr_cmd_e          cmd_q, cmd_d;
  logic [ROW_W-1:0]  addr_q, addr_d;
  logic              cke_q, cke_d, done_q, done_d, err_q, err_d;
  logic              issue, gap_load, gap_zero, wait_load, wait_zero, tmr_start;
  logic [GAP_W-1:0]  gap_val;

  sdram_boot_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  sdram_boot_downcnt #(.W(GAP_W), .RST_VAL('0)) u_gap (
    .clk(clk), .rst_n(core_rst_n), .load(gap_load), .load_val(gap_val),
    .dec(phase_q == SEQ_SPACING), .zero(gap_zero)
  );

  sdram_boot_downcnt #(.W(WAIT_W), .RST_VAL(WAIT_RELOAD)) u_wait (
    .clk(clk), .rst_n(core_rst_n), .load(wait_load), .load_val(WAIT_RELOAD),
    .dec((phase_q == SEQ_HANDSHAKE) && !ctrl_ready), .zero(wait_zero)
  );

  sdram_boot_refresh_tmr #(.INTERVAL(REFI_CYCLES)) u_tmr (
    .clk(clk), .rst_n(core_rst_n), .start(tmr_start), .ack(refresh_ack),
    .req(refresh_req)
  );

  // next-state logic
  always_comb begin
    phase_d   = phase_q;
    step_d    = step_q;
    refs_d    = refs_q;
    cke_d     = cke_q;
    done_d    = done_q;
    err_d     = err_q;
    cmd_d     = CMD_NOP;
    addr_d    = '0;
    issue     = 1'b0;
    gap_load  = 1'b0;
    gap_val   = '0;
    wait_load = 1'b0;
    tmr_start = 1'b0;

    unique case (phase_q)
      SEQ_HANDSHAKE: begin
        if (ctrl_ready) begin
          issue = 1'b1;
        end else if (wait_zero) begin
          phase_d = SEQ_FAULT;
          err_d   = 1'b1;
        end
      end
      SEQ_SPACING: begin
        if (gap_zero) begin
          if (step_q == STEP_REF && refs_q != REFS_W'(INIT_REFRESHES)) begin
            issue = 1'b1;
          end else if (step_q == STEP_LMR) begin
            phase_d   = SEQ_RUNNING;
            done_d    = 1'b1;
            tmr_start = 1'b1;
          end else begin
            phase_d   = SEQ_HANDSHAKE;
            wait_load = 1'b1;
            unique case (step_q)
              STEP_CKE: step_d = STEP_PRE;
              STEP_PRE: step_d = STEP_REF;
              default:  step_d = STEP_LMR;
            endcase
          end
        end
      end
      default: ;
    endcase

    if (issue) begin
      phase_d  = SEQ_SPACING;
      gap_load = 1'b1;
      unique case (step_q)
        STEP_CKE: begin
          cke_d   = 1'b1;
          gap_val = GAP_W'(PWRUP_CYCLES - 1);
        end
        STEP_PRE: begin
          cmd_d      = CMD_PRE;
          addr_d[10] = 1'b1;
          gap_val    = GAP_W'(T_PRE - 1);
        end
        STEP_REF: begin
          cmd_d   = CMD_REF;
          refs_d  = refs_q + 1'b1;
          gap_val = GAP_W'(T_RFC - 1);
        end
        STEP_LMR: begin
          cmd_d   = CMD_LMR;
          addr_d  = MODE_WORD;
          gap_val = GAP_W'(T_MRD - 1);
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      phase_q <= SEQ_HANDSHAKE;
      step_q  <= STEP_CKE;
      refs_q  <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      refs_q  <= refs_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      cke_q   <= cke_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr       = addr_q;
  assign ba         = BANK_W'(0);
  assign cke        = cke_q;
  assign init_done  = done_q;
  assign init_error = err_q;
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
  parameter int unsigned  PWRUP_CYCLES = 1,
  parameter int unsigned  T_PRE        = 3,
  parameter int unsigned  T_RFC        = 7,
  parameter int unsigned  T_MRD        = 2,
  parameter int unsigned  ADDR_W       = 13,
  parameter int unsigned  BANK_W       = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              init_error,
  input logic              refresh_req,
  input logic              refresh_ack
);
  logic [3:0]  code;
  logic [2:0]  last_q;
  logic        cke_q;
  int unsigned since_q;
  int unsigned need;

  assign code = {cs_n, ras_n, cas_n, we_n};

  always_comb begin
    unique case (last_q)
      3'd1:    need = PWRUP_CYCLES;
      3'd2:    need = T_PRE;
      3'd3:    need = T_RFC;
      3'd4:    need = T_MRD;
      default: need = 0;
    endcase
  end

  // cycles since the last command or CKE rise, and its kind
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 3'd0;
      since_q <= 0;
      cke_q   <= 1'b0;
    end else begin
      cke_q <= cke;
      if (cke && !cke_q) begin
        last_q  <= 3'd1;
        since_q <= 1;
      end else if (code != 4'b0111) begin
        last_q  <= (code == 4'b0010) ? 3'd2 : (code == 4'b0001) ? 3'd3 : 3'd4;
        since_q <= 1;
      end else if (since_q != 32'hFFFF_FFFF) begin
        since_q <= since_q + 1;
      end
    end
  end

  a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    code inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});

  a_r5_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    code == 4'b0010 |-> addr[10]);

  a_r6_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    code == 4'b0000 |-> (addr == MODE_WORD && ba == '0));

  a_r2_quiet_without_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> code == 4'b0111);

  a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 4'b0111 && last_q != 3'd0) |-> since_q >= need);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> code == 4'b0111);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_error |=> (init_error && !init_done && code == 4'b0111));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

  a_r10_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);

  a_r12_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
  .PWRUP_CYCLES (PWRUP_CYCLES),
  .T_PRE        (T_PRE),
  .T_RFC        (T_RFC),
  .T_MRD        (T_MRD),
  .ADDR_W       (ROW_W),
  .BANK_W       (BANK_W),
  .MODE_WORD    (MODE_WORD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .addr        (addr),
  .init_done   (init_done),
  .init_error  (init_error),
  .refresh_req (refresh_req),
  .refresh_ack (refresh_ack)
);

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;
  localparam int P    = 40;
  localparam int LIM  = 16;
  localparam int RET  = 1024;
  localparam int MHZ  = 100;
  localparam int ROWS = 8192;
  localparam int MARG = 2;
  localparam int REFI = RET * MHZ / ROWS - MARG;
  localparam int TP = 3, TR = 7, TM = 2, NR = 8;
  localparam logic [12:0] EXP_MODE = 13'((1 << 9) | (3 << 4));

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, ctrl_ready, refresh_ack;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, init_error, refresh_req;
  logic [1:0]  ba;
  logic [12:0] addr;

  sdram_boot_seq #(
    .PWRUP_CYCLES(P), .WAIT_LIMIT(LIM), .RETENTION_US(RET),
    .SDCLK_MHZ(MHZ), .ROW_COUNT(ROWS), .REFRESH_MARGIN(MARG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_ready(ctrl_ready), .refresh_ack(refresh_ack),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done), .init_error(init_error),
    .refresh_req(refresh_req)
  );

  int n_chk = 0, n_fail = 0;
  int cyc;
  int cke_c, pre_c, lmr_c, done_c, err_c, nref, nreq, nfall, extra, late_cmd, cke_drop;
  int ref_c[NR];
  int req_rise[16], req_fall[16];
  logic        pre_a10;
  logic [12:0] lmr_addr;
  logic [1:0]  lmr_ba;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_boot(input int hold_start, input int hold_cke, input int stall_ref,
                          input int hold_lmr, input bit kill_pre, input int ack_delay,
                          input int ncyc, input bit chk_reset);
    int   ack_at;
    logic req_prev, cke_seen;
    logic [3:0] code;
    rst_n = 1'b0; refresh_ack = 1'b0; ctrl_ready = (hold_start == 0);
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      check_eq("R1 cke", cke, 0);
      check_eq("R1 cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      check_eq("R1 flags", {init_done, init_error, refresh_req}, 0);
    end
    cke_c = -1; pre_c = -1; lmr_c = -1; done_c = -1; err_c = -1;
    nref = 0; nreq = 0; nfall = 0; extra = 0; late_cmd = 0; cke_drop = 0;
    pre_a10 = 1'b0; lmr_addr = '0; lmr_ba = '0;
    ack_at = -1; req_prev = 1'b0; cke_seen = 1'b0;
    rst_n = 1'b1; cyc = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      cyc++;
      code = {cs_n, ras_n, cas_n, we_n};
      if (cke && !cke_seen) begin cke_seen = 1'b1; cke_c = cyc; end
      if (!cke && cke_seen) cke_drop++;
      if (code != 4'b0111 && (done_c >= 0 || err_c >= 0)) late_cmd++;
      case (code)
        4'b0111: ;
        4'b0010: begin pre_c = cyc; pre_a10 = addr[10]; end
        4'b0001: begin if (nref < NR) ref_c[nref] = cyc; nref++; end
        4'b0000: begin lmr_c = cyc; lmr_addr = addr; lmr_ba = ba; end
        default: extra++;
      endcase
      if (init_done && done_c < 0) done_c = cyc;
      if (init_error && err_c < 0) err_c = cyc;
      if (refresh_req && !req_prev) begin
        if (nreq < 16) req_rise[nreq] = cyc;
        nreq++;
        ack_at = cyc + ack_delay;
      end
      if (!refresh_req && req_prev) begin
        if (nfall < 16) req_fall[nfall] = cyc;
        nfall++;
      end
      req_prev = refresh_req;
      refresh_ack = (cyc == ack_at);
      ctrl_ready = 1'b1;
      if (cyc < hold_start) ctrl_ready = 1'b0;
      if (cke_c >= 0 && cyc < cke_c + hold_cke) ctrl_ready = 1'b0;
      if (nref > 0 && cyc < ref_c[0] + stall_ref) ctrl_ready = 1'b0;
      if (nref >= NR && cyc < ref_c[NR-1] + hold_lmr) ctrl_ready = 1'b0;
      if (kill_pre && pre_c >= 0) ctrl_ready = 1'b0;
    end
    refresh_ack = 1'b0;
  endtask

  task automatic check_full(input int hold_start, input int hold_lmr, input int ack_delay);
    int s, e_pre, e_ref0, e_lmr, e_done;
    s      = (hold_start > 2) ? hold_start - 2 : 0;
    e_pre  = 4 + P + s;
    e_ref0 = e_pre + TP + 1;
    e_lmr  = e_ref0 + TR * (NR - 1) + TR + 1;
    if (e_ref0 + TR * (NR - 1) + hold_lmr + 1 > e_lmr)
      e_lmr = e_ref0 + TR * (NR - 1) + hold_lmr + 1;
    e_done = e_lmr + TM;
    check_eq("R8 cke rise", cke_c, 3 + s);
    check_eq("R3 precharge cycle", pre_c, e_pre);
    check_eq("R3 powerup distance", pre_c - cke_c, P + 1);
    check_eq("R5 precharge A10", pre_a10, 1);
    check_eq("R2 refresh count", nref, NR);
    check_eq("R2 foreign commands", extra, 0);
    for (int i = 0; i < NR; i++)
      check_eq("R4 refresh cycle", ref_c[i], e_ref0 + TR * i);
    check_eq("R8 load-mode cycle", lmr_c, e_lmr);
    check_eq("R6 mode word", lmr_addr, EXP_MODE);
    check_eq("R6 bank address", lmr_ba, 0);
    check_eq("R7 done cycle", done_c, e_done);
    check_eq("R7 commands after done", late_cmd, 0);
    check_eq("R9 no error", err_c, -1);
    check_eq("R12 cke drop", cke_drop, 0);
    check_eq("R11 request count", (nreq >= 3) ? 1 : 0, 1);
    for (int k = 0; k < 3; k++) begin
      check_eq("R11 request rise", req_rise[k], e_done + REFI * (k + 1));
      check_eq("R10 request fall", req_fall[k], req_rise[k] + ack_delay + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 plus ready-high sequence
    run_boot(0, 0, 0, 0, 1'b0, 0, 220, 1'b1);
    check_full(0, 0, 0);
    // R8: ready gaps after first refresh and before load-mode, late ack
    run_boot(0, 0, 3, 10, 1'b0, 4, 220, 1'b0);
    check_full(0, 10, 4);
    // R8: ready held low from reset shifts the whole sequence
    run_boot(10, 0, 0, 0, 1'b0, 8, 220, 1'b0);
    check_full(10, 0, 8);
    // R9: ready never seen before CKE
    run_boot(40, 0, 0, 0, 1'b0, 0, 40, 1'b0);
    check_eq("R9 error before CKE", err_c, 2 + LIM);
    check_eq("R9 cke never raised", cke_c, -1);
    // R9: ready lost after precharge
    run_boot(0, 0, 0, 0, 1'b1, 0, 120, 1'b0);
    check_eq("R9 error in refresh wait", err_c, 7 + P + LIM);
    check_eq("R9 no refresh after fault", nref, 0);
    check_eq("R9 no done after fault", done_c, -1);
    check_eq("R12 cke kept after fault", cke, 1);
    check_eq("R9 commands after fault", late_cmd, 0);
    // R8/R9 sweep of ready hold after CKE rise
    for (int L = 0; L <= P + LIM + 1; L++) begin
      run_boot(0, L, 0, 0, 1'b0, 0, P + LIM + 10, 1'b0);
      if (L < P + LIM) begin
        check_eq("R8 sweep precharge", pre_c, 4 + ((L > P) ? L : P));
        check_eq("R8 sweep no error", err_c, -1);
      end else begin
        check_eq("R9 sweep error", err_c, 3 + P + LIM);
        check_eq("R9 sweep no precharge", pre_c, -1);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule